// File: doc/BRIEF.md
# Low-Speed Serial Bus NRZI Receiver

This block receives low-speed USB packets from the D+/D- wire pair. A system clock samples the pair at about eleven clocks per bit. Both wires pass through a synchronizer. A bit-timing stage then restarts its phase counter on every line transition and samples each bit near its centre, so the receiver follows a sender whose bit rate is about one percent off nominal.

A framing stage looks for a J-to-K transition while the line is idle. It then follows the alternating sync pattern until it sees two K bit times in a row. At that point it raises a packet-start pulse. From then on it decodes NRZI, drops stuffed bits and passes data bits to a deserializer. The deserializer builds bytes with the least significant bit first and emits each byte as a one-clock valid pulse.

SE0 at a bit sample ends the packet. A byte beyond the configured buffer size aborts the packet with an overflow pulse. CRC checking, PID decoding and the transmit path are not part of this block.

Top module: `ls_nrzi_rx`

## Requirements
- R1: While reset is asserted and after it is released with the line idle (J), rx_start, rx_valid, rx_eop and rx_overflow all stay low.
- R2: Line states are taken as {D+, D-}: J = 01, K = 10, SE0 = 00. A J-to-K transition on an idle line starts sync tracking. When two consecutive bit samples read K, rx_start pulses for one clock. The sync pattern itself is never output as a byte.
- R3: If two consecutive bit samples during sync tracking read J, or a sample reads SE0, the receiver goes back to searching for an idle-line J-to-K transition and does not raise rx_start.
- R4: A data bit is 1 when its sampled line state equals the previous bit's state and 0 when it differs. Eight data bits form a byte with the first bit in bit 0. Each byte appears on rx_data during a one-clock rx_valid pulse, and two rx_valid pulses are never on adjacent clocks.
- R5: A bit that follows six consecutive decoded 1 bits is discarded and not shifted into a byte. The final sync bit counts as the first of those 1 bits.
- R6: An SE0 sample during the data phase makes rx_eop pulse once. The receiver then returns to searching.
- R7: At most BUF_BYTES bytes are output per packet. When byte number BUF_BYTES+1 completes, rx_overflow pulses instead of rx_valid and the packet is dropped, with no rx_eop for it.
- R8: Packets are decoded correctly when the sender's bit period is 1% shorter or 1% longer than CLKS_PER_BIT clocks.
- R9: At most one of rx_start, rx_valid, rx_eop and rx_overflow is high in any clock. rx_valid, rx_eop and rx_overflow occur only between an rx_start and the end of that packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, nominally CLKS_PER_BIT times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_dp | input | 1 | D+ line, asynchronous |
| usb_dm | input | 1 | D- line, asynchronous |
| rx_start | output | 1 | One-clock pulse when the end of sync is found |
| rx_valid | output | 1 | One-clock pulse for each received byte |
| rx_data | output | 8 | Received byte, valid while rx_valid is high |
| rx_eop | output | 1 | One-clock pulse at the SE0 that ends a packet |
| rx_overflow | output | 1 | One-clock pulse when a packet exceeds BUF_BYTES bytes |

## Verification
The hardest case to reach from the ports is a sampling phase that has drifted across a long run without transitions. This only happens when the sender's rate is off and the data forces the longest gaps between edges, such as runs of six ones with their stuffed bits. The bench drives the wires from a picosecond bit period that is independent of the clock period, at nominal rate and at ±1%. It encodes every byte value from 0 to 255 across a series of full-buffer packets, together with packets built to force stuffing right after sync and back to back. The same drivers also produce a broken sync, an SE0 inside sync and a packet one byte too long.

// File: rtl/ls_nrzi_rx_pkg.sv
package ls_nrzi_rx_pkg;

   // Line state as {D+, D-}
   typedef enum logic [1:0] {
      LS_SE0 = 2'b00,
      LS_J   = 2'b01,
      LS_K   = 2'b10,
      LS_SE1 = 2'b11
   } line_t;

   typedef enum logic [1:0] {
      FR_HUNT = 2'b00,
      FR_SYNC = 2'b01,
      FR_DATA = 2'b10
   } frame_st_t;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/lsrx_sync.sv
module lsrx_sync #(
   parameter int             STAGES  = 2,
   parameter int             W       = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/lsrx_bit_clock.sv
module lsrx_bit_clock
   import ls_nrzi_rx_pkg::*;
#(
   parameter int CLKS_PER_BIT = 11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] line_in,
   output line_t      ln_cur,
   output line_t      ln_prev,
   output logic       bit_stb
);

   localparam int            CW     = $clog2(CLKS_PER_BIT);
   localparam logic [CW-1:0] LAST_C = CW'(CLKS_PER_BIT - 1);
   localparam logic [CW-1:0] MID_C  = CW'(CLKS_PER_BIT / 2);

   logic [CW-1:0] phase_cnt;
   logic          trans;

   assign ln_cur = line_t'(line_in);
   assign trans  = (ln_cur != ln_prev);

   // Every transition restarts the phase so the next sample lands mid-bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ln_prev   <= LS_J;
         phase_cnt <= '0;
      end else begin
         ln_prev <= ln_cur;
         if (trans)                  phase_cnt <= '0;
         else if (phase_cnt == LAST_C) phase_cnt <= '0;
         else                        phase_cnt <= phase_cnt + 1'b1;
      end
   end

   assign bit_stb = (phase_cnt == MID_C);

endmodule

// File: rtl/lsrx_frame.sv
module lsrx_frame
   import ls_nrzi_rx_pkg::*;
#(
   parameter int STUFF_RUN = 6
) (
   input  logic  clk,
   input  logic  rst_n,
   input  line_t ln_cur,
   input  line_t ln_prev,
   input  logic  bit_stb,
   input  logic  abort,
   output logic  pkt_begin,
   output logic  pkt_eop,
   output logic  dbit_vld,
   output logic  dbit
);

   localparam int            OW      = $clog2(STUFF_RUN + 1);
   localparam logic [OW-1:0] RUN_C   = OW'(STUFF_RUN);
   localparam logic [OW-1:0] ONE_C   = OW'(1);

   frame_st_t      st;
   line_t          last_ls;
   logic [OW-1:0]  ones;
   logic           is_se0;
   logic           stuffed;
   logic           idle_to_k;

   assign is_se0    = (ln_cur == LS_SE0);
   assign stuffed   = (ones == RUN_C);
   assign idle_to_k = (ln_prev == LS_J) && (ln_cur == LS_K);

   assign pkt_begin = bit_stb && (st == FR_SYNC) && (ln_cur == LS_K) && (last_ls == LS_K);
   assign pkt_eop   = bit_stb && (st == FR_DATA) && is_se0;
   assign dbit_vld  = bit_stb && (st == FR_DATA) && !is_se0 && !stuffed;
   assign dbit      = (ln_cur == last_ls);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= FR_HUNT;
         last_ls <= LS_J;
         ones    <= '0;
      end else begin
         unique case (st)
            FR_HUNT: begin
               if (idle_to_k) begin
                  st      <= FR_SYNC;
                  last_ls <= LS_J;
               end
            end
            FR_SYNC: begin
               if (bit_stb) begin
                  if (is_se0) begin
                     st <= FR_HUNT;
                  end else if (ln_cur == LS_K && last_ls == LS_K) begin
                     st      <= FR_DATA;
                     ones    <= ONE_C;   // closing sync bit decodes as 1
                     last_ls <= LS_K;
                  end else if (ln_cur == LS_J && last_ls == LS_J) begin
                     st <= FR_HUNT;
                  end else begin
                     last_ls <= ln_cur;
                  end
               end
            end
            FR_DATA: begin
               if (abort) begin
                  st <= FR_HUNT;
               end else if (bit_stb) begin
                  if (is_se0) begin
                     st <= FR_HUNT;
                  end else begin
                     last_ls <= ln_cur;
                     if (stuffed)   ones <= '0;
                     else if (dbit) ones <= ones + 1'b1;
                     else           ones <= '0;
                  end
               end
            end
            default: st <= FR_HUNT;
         endcase
      end
   end

endmodule

// File: rtl/lsrx_deser.sv
module lsrx_deser
   import ls_nrzi_rx_pkg::*;
#(
   parameter int BUF_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_begin,
   input  logic              dbit_vld,
   input  logic              dbit,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_dat,
   output logic              ovf
);

   localparam int            RW    = $clog2(BUF_BYTES + 1);
   localparam int            BW    = $clog2(BYTE_W);
   localparam logic [RW-1:0] FULL_C = RW'(BUF_BYTES);
   localparam logic [BW-1:0] TOP_C  = BW'(BYTE_W - 1);

   logic [BYTE_W-1:0] shreg;
   logic [BW-1:0]     bit_idx;
   logic [RW-1:0]     remain;
   logic              byte_done;

   assign byte_done = dbit_vld && (bit_idx == TOP_C);
   assign byte_vld  = byte_done && (remain != '0);
   assign ovf       = byte_done && (remain == '0);
   assign byte_dat  = {dbit, shreg[BYTE_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         bit_idx <= '0;
         remain  <= '0;
      end else if (pkt_begin) begin
         bit_idx <= '0;
         remain  <= FULL_C;
      end else if (dbit_vld) begin
         shreg   <= {dbit, shreg[BYTE_W-1:1]};
         bit_idx <= bit_idx + 1'b1;
         if (byte_vld) remain <= remain - 1'b1;
      end
   end

endmodule

// File: rtl/ls_nrzi_rx.sv
module ls_nrzi_rx
   import ls_nrzi_rx_pkg::*;
#(
   parameter int CLKS_PER_BIT = 11,
   parameter int BUF_BYTES    = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int STUFF_RUN    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              usb_dp,
   input  logic              usb_dm,
   output logic              rx_start,
   output logic              rx_valid,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_eop,
   output logic              rx_overflow
);

   if (CLKS_PER_BIT < 5) begin : g_bad_ratio
      $error("CLKS_PER_BIT must be at least 5");
   end
   if (BUF_BYTES < 1) begin : g_bad_buf
      $error("BUF_BYTES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (STUFF_RUN < 1) begin : g_bad_stuff
      $error("STUFF_RUN must be at least 1");
   end

   logic [1:0] line_s;
   line_t      ln_cur;
   line_t      ln_prev;
   logic       bit_stb;
   logic       dbit_vld;
   logic       dbit;

   lsrx_sync #(
      .STAGES  (SYNC_STAGES),
      .W       (2),
      .RST_VAL (LS_J)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({usb_dp, usb_dm}),
      .q     (line_s)
   );

   lsrx_bit_clock #(
      .CLKS_PER_BIT (CLKS_PER_BIT)
   ) u_bclk (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (line_s),
      .ln_cur  (ln_cur),
      .ln_prev (ln_prev),
      .bit_stb (bit_stb)
   );

   lsrx_frame #(
      .STUFF_RUN (STUFF_RUN)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .ln_cur    (ln_cur),
      .ln_prev   (ln_prev),
      .bit_stb   (bit_stb),
      .abort     (rx_overflow),
      .pkt_begin (rx_start),
      .pkt_eop   (rx_eop),
      .dbit_vld  (dbit_vld),
      .dbit      (dbit)
   );

   lsrx_deser #(
      .BUF_BYTES (BUF_BYTES)
   ) u_deser (
      .clk       (clk),
      .rst_n     (rst_n),
      .pkt_begin (rx_start),
      .dbit_vld  (dbit_vld),
      .dbit      (dbit),
      .byte_vld  (rx_valid),
      .byte_dat  (rx_data),
      .ovf       (rx_overflow)
   );

endmodule

// File: rtl/ls_nrzi_rx_checker.sv
module ls_nrzi_rx_checker #(
   parameter int BUF_BYTES = 8
) (
   input logic clk,
   input logic rst_n,
   input logic rx_start,
   input logic rx_valid,
   input logic rx_eop,
   input logic rx_overflow
);

   localparam int NW = $clog2(BUF_BYTES + 2) + 1;

   logic          in_pkt;
   logic [NW-1:0] nbytes;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_pkt <= 1'b0;
         nbytes <= '0;
      end else begin
         if (rx_start) begin
            in_pkt <= 1'b1;
            nbytes <= '0;
         end else begin
            if (rx_eop || rx_overflow) in_pkt <= 1'b0;
            if (rx_valid)              nbytes <= nbytes + 1'b1;
         end
      end
   end

   assert_quiet_in_reset_R1: assert property (@(posedge clk)
      !rst_n |-> !(rx_start || rx_valid || rx_eop || rx_overflow));

   assert_start_outside_pkt_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_start |-> !in_pkt);

   assert_valid_in_pkt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> in_pkt);

   assert_valid_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_eop_in_pkt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_eop |-> in_pkt);

   assert_valid_below_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (nbytes < NW'(BUF_BYTES)));

   assert_no_overflow_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overflow |-> (in_pkt && nbytes == NW'(BUF_BYTES)));

   assert_single_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_start, rx_valid, rx_eop, rx_overflow}));

endmodule

bind ls_nrzi_rx ls_nrzi_rx_checker #(
   .BUF_BYTES (BUF_BYTES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_start    (rx_start),
   .rx_valid    (rx_valid),
   .rx_eop      (rx_eop),
   .rx_overflow (rx_overflow)
);

// File: tb/ls_nrzi_rx_tb.sv
`timescale 1ps/1ps
module ls_nrzi_rx_tb;

   localparam int BUF      = 8;
   localparam int BIT_NOM  = 44000;
   localparam int BIT_FAST = 43560;
   localparam int BIT_SLOW = 44440;
   localparam logic [1:0] J_ST = 2'b01;
   localparam logic [1:0] K_ST = 2'b10;
   localparam logic [1:0] Z_ST = 2'b00;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       usb_dp = 1'b0;
   logic       usb_dm = 1'b1;
   logic       rx_start, rx_valid, rx_eop, rx_overflow;
   logic [7:0] rx_data;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int n_start = 0, n_eop = 0, n_ovf = 0, n_multi = 0, n_evt = 0;
   int got_n = 0;
   logic [7:0] got [32];
   logic [7:0] tx  [16];

   always #2000 clk = ~clk;

   ls_nrzi_rx #(.CLKS_PER_BIT(11), .BUF_BYTES(BUF)) u_dut (
      .clk(clk), .rst_n(rst_n), .usb_dp(usb_dp), .usb_dm(usb_dm),
      .rx_start(rx_start), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_eop(rx_eop), .rx_overflow(rx_overflow)
   );

   always @(negedge clk) begin
      if (rx_start) n_start++;
      if (rx_eop) n_eop++;
      if (rx_overflow) n_ovf++;
      if (rx_start || rx_valid || rx_eop || rx_overflow) n_evt++;
      if ((int'(rx_start) + int'(rx_valid) + int'(rx_eop) + int'(rx_overflow)) > 1) n_multi++;
      if (rx_valid && got_n < 32) begin
         got[got_n] = rx_data;
         got_n++;
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic put(input logic [1:0] ls, input int ps);
      {usb_dp, usb_dm} = ls;
      #(ps);
   endtask

   // Encode n bytes of tx[] as a full packet: idle, sync, NRZI data with stuffing, EOP
   task automatic send_pkt(input int n, input int bp);
      logic [1:0] lvl;
      int ones;
      for (int i = 0; i < 4; i++) put(J_ST, bp);
      put(K_ST, bp); put(J_ST, bp); put(K_ST, bp); put(J_ST, bp);
      put(K_ST, bp); put(J_ST, bp); put(K_ST, bp); put(K_ST, bp);
      lvl  = K_ST;
      ones = 1;
      for (int b = 0; b < n; b++) begin
         for (int k = 0; k < 8; k++) begin
            if (tx[b][k]) ones++;
            else begin
               ones = 0;
               lvl = ~lvl;
            end
            put(lvl, bp);
            if (ones == 6) begin
               lvl = ~lvl;
               put(lvl, bp);
               ones = 0;
            end
         end
      end
      put(Z_ST, bp); put(Z_ST, bp);
      for (int i = 0; i < 4; i++) put(J_ST, bp);
   endtask

   task automatic run_pkt(input int n, input int bp, input string req);
      int s0, e0, o0, exp_n;
      s0 = n_start; e0 = n_eop; o0 = n_ovf;
      got_n = 0;
      send_pkt(n, bp);
      repeat (20) @(negedge clk);
      exp_n = (n > BUF) ? BUF : n;
      chk("R2", "rx_start pulses", n_start - s0, 1);
      if (n > BUF) begin
         chk("R7", "rx_overflow pulses", n_ovf - o0, 1);
         chk("R7", "rx_eop after overflow", n_eop - e0, 0);
      end else begin
         chk("R6", "rx_eop pulses", n_eop - e0, 1);
         chk("R7", "rx_overflow pulses", n_ovf - o0, 0);
      end
      chk(req, "byte count", got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++) begin
         checks++;
         if (got[i] !== tx[i]) begin
            fails++;
            $display("FAIL %s byte %0d: actual %02h expected %02h", req, i, got[i], tx[i]);
         end
      end
   endtask

   initial begin
      int rate;
      int s0;
      repeat (5) @(negedge clk);
      chk("R1", "events during reset", n_evt, 0);
      rst_n = 1'b1;
      repeat (30) @(negedge clk);
      chk("R1", "events after reset", n_evt, 0);
      #1;

      // R4 / R8: every byte value once, across nominal, fast and slow senders
      for (int p = 0; p < 32; p++) begin
         for (int i = 0; i < BUF; i++) tx[i] = 8'(p * BUF + i);
         rate = (p % 3 == 0) ? BIT_NOM : ((p % 3 == 1) ? BIT_FAST : BIT_SLOW);
         run_pkt(BUF, rate, (rate == BIT_NOM) ? "R4" : "R8");
      end

      // R5: stuffing right after sync and in long runs of ones
      tx[0] = 8'h3F; tx[1] = 8'hFF; tx[2] = 8'hFF; tx[3] = 8'h7E;
      tx[4] = 8'hFC; tx[5] = 8'h7F; tx[6] = 8'h01; tx[7] = 8'hFF;
      run_pkt(8, BIT_NOM, "R5");
      run_pkt(8, BIT_FAST, "R5");
      run_pkt(8, BIT_SLOW, "R5");
      tx[0] = 8'h1F; tx[1] = 8'hC0;
      run_pkt(2, BIT_SLOW, "R5");

      // R6: empty packet, sync then EOP
      run_pkt(0, BIT_NOM, "R6");
      tx[0] = 8'hA5;
      run_pkt(1, BIT_FAST, "R6");

      // R7: one byte beyond the buffer
      for (int i = 0; i < 9; i++) tx[i] = 8'(8'h11 * (i + 1));
      run_pkt(9, BIT_NOM, "R7");
      for (int i = 0; i < 8; i++) tx[i] = 8'(8'h0F + i);
      run_pkt(8, BIT_NOM, "R7");

      // R3: broken sync (J J) and SE0 inside sync
      s0 = n_start; got_n = 0;
      for (int i = 0; i < 4; i++) put(J_ST, BIT_NOM);
      put(K_ST, BIT_NOM); put(J_ST, BIT_NOM); put(J_ST, BIT_NOM); put(J_ST, BIT_NOM);
      for (int i = 0; i < 4; i++) put(J_ST, BIT_NOM);
      repeat (20) @(negedge clk);
      chk("R3", "rx_start after J J in sync", n_start - s0, 0);
      #1;
      put(K_ST, BIT_NOM); put(J_ST, BIT_NOM); put(K_ST, BIT_NOM);
      put(Z_ST, BIT_NOM); put(Z_ST, BIT_NOM);
      for (int i = 0; i < 4; i++) put(J_ST, BIT_NOM);
      repeat (20) @(negedge clk);
      chk("R3", "rx_start after SE0 in sync", n_start - s0, 0);
      chk("R3", "bytes after aborted sync", got_n, 0);
      #1;
      tx[0] = 8'h5A; tx[1] = 8'hC3;
      run_pkt(2, BIT_NOM, "R3");

      chk("R9", "cycles with more than one event", n_multi, 0);
      summary();
      $finish;
   end

endmodule